// File: doc/BRIEF.md
# Warp Shared-Memory Bank Conflict Serialiser

This block takes one shared-memory request from a 32-lane warp. Each lane supplies a byte address and an active flag. The block works out which bank each active lane hits. It then splits the request into the fewest passes so that, in any one pass, each bank delivers a single 32-bit word. Lanes that name the same word in a bank are served together in that pass, so the word is broadcast to all of them. Lanes that name different words in the same bank are pushed into later passes.

The request enters on a valid/ready port. `req_ready` equals `done`, so the upstream source waits while a request is being served. Once a request is accepted, the block shows one pass per cycle on `grant_mask`, flagged by `grant_valid`. The grant side is a plain control output with no back-pressure: each pass is shown for exactly one cycle. When the last pass has been shown, `done` rises and `degree` holds the number of passes that the request needed.

Top module: `smem_bank_arbiter`

## Requirements
- R1: A lane's bank is its word index (byte address shifted right by 2) modulo 32. Active lanes in different banks are granted in the same pass.
- R2: Active lanes whose addresses agree above bit 1 are served in one pass as a broadcast, even when their byte offsets (bits 1:0) differ.
- R3: Active lanes in the same bank with different word indices are granted in different passes. For example, addresses 0 and 128 conflict, while 0 and 4 or 0 and 132 do not.
- R4: Two lanes target the same word only if all address bits above bit 1 match, not just the bank bits. For example, addresses 0 and 4096 are different words in bank 0.
- R5: In each pass, every bank serves the word of its lowest-numbered lane that has not yet been served.
- R6: When `done` rises after a request, `degree` equals the largest number of distinct words requested in any single bank.
- R7: Inactive lanes are never granted and do not add to `degree`.
- R8: A request with no active lanes leaves `done` high, never raises `grant_valid`, and reports `degree` = 0.
- R9: `req_ready` equals `done`. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A `req_valid` pulse while the block is busy is ignored.
- R10: After reset, `done` = 1, `req_ready` = 1, `grant_valid` = 0 and `degree` = 0.
- R11: The first pass appears in the cycle after acceptance, with one pass per cycle. `done` rises in the cycle after the last pass, and every active lane is granted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request (equals `done`) |
| req_active | input | LANES | Per-lane active flag |
| req_addr | input | LANES*AW | Per-lane byte address; lane i is in bits [i*AW +: AW] |
| grant_valid | output | 1 | A pass is being shown this cycle |
| grant_mask | output | LANES | Lanes served in the current pass |
| degree | output | $clog2(LANES+1) | Passes used by the current or last request |
| done | output | 1 | No lanes pending |

## Verification
Assertions check several properties on every cycle:
- the lowest pending lane is always granted, and no granted lanes split one bank across two words;
- grants stay inside the pending set, and every busy cycle makes progress;
- the pass count steps by one per pass;
- a request arriving while busy never changes the pending set.

Other behaviours only the bench scenarios can show. These are that the pass count equals the worst per-bank word count, that the full-address compare is used rather than the bank bits alone, and that inactive lanes are ignored. The bench also confirms the exact grant sequence for strided, broadcast and wrapping address patterns.

// File: rtl/smbc_pkg.sv
package smbc_pkg;
  // byte offset inside one 32-bit word
  localparam int unsigned OFFS_BITS = 2;

  // isolate lowest set bit of a mask
  function automatic logic [63:0] lowest_bit(input logic [63:0] m);
    return m & (~m + 64'd1);
  endfunction
endpackage

// File: rtl/smbc_bank_map.sv
module smbc_bank_map #(
  parameter int unsigned AW        = 16,
  parameter int unsigned BANK_BITS = 5
) (
  input  logic [AW-1:0]                       addr,
  output logic [BANK_BITS-1:0]                bank,
  output logic [AW-smbc_pkg::OFFS_BITS-1:0]   word
);
  import smbc_pkg::*;

  assign word = addr[AW-1:OFFS_BITS];
  assign bank = addr[OFFS_BITS +: BANK_BITS];
endmodule

// File: rtl/smbc_pass_picker.sv
module smbc_pass_picker #(
  parameter int unsigned LANES     = 32,
  parameter int unsigned BANK_BITS = 5,
  parameter int unsigned WW        = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           pend,
  input  logic [LANES*BANK_BITS-1:0] bank_f,
  input  logic [LANES*WW-1:0]        word_f,
  output logic [LANES-1:0]           grant
);
  import smbc_pkg::*;

  // each lane looks for the lowest pending lane in its bank and joins it
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic          found;
      logic [WW-1:0] lead;
      found = 1'b0;
      lead  = '0;
      for (int j = 0; j < LANES; j++) begin
        if (j <= i && !found && pend[j] &&
            bank_f[j*BANK_BITS +: BANK_BITS] == bank_f[i*BANK_BITS +: BANK_BITS]) begin
          found = 1'b1;
          lead  = word_f[j*WW +: WW];
        end
      end
      grant[i] = pend[i] && found && (word_f[i*WW +: WW] == lead);
    end
  end

  // pairwise scan for two granted lanes in one bank with different words
  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (grant[i] && grant[j] &&
            bank_f[i*BANK_BITS +: BANK_BITS] == bank_f[j*BANK_BITS +: BANK_BITS] &&
            word_f[i*WW +: WW] != word_f[j*WW +: WW])
          clash = 1'b1;
  end

  logic [63:0] pend_w, low_w, grant_w;
  assign pend_w  = 64'(pend);
  assign grant_w = 64'(grant);
  assign low_w   = lowest_bit(pend_w);

  AST_ONE_WORD_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !clash); // R3
  AST_LEADER_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> ((grant_w & low_w) != 64'd0)); // R5
  AST_GRANT_IN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0); // R7
endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BANKS = 32,
  parameter int unsigned AW    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [LANES-1:0]              req_active,
  input  logic [LANES*AW-1:0]           req_addr,
  output logic                          grant_valid,
  output logic [LANES-1:0]              grant_mask,
  output logic [$clog2(LANES+1)-1:0]    degree,
  output logic                          done
);
  import smbc_pkg::*;

  localparam int unsigned BANK_BITS = $clog2(BANKS);
  localparam int unsigned WW        = AW - OFFS_BITS;
  localparam int unsigned DEG_W     = $clog2(LANES + 1);

  logic [LANES-1:0]           pend_q;
  logic [LANES*AW-1:0]        addr_q;
  logic [DEG_W-1:0]           deg_q;
  logic [LANES*BANK_BITS-1:0] bank_f;
  logic [LANES*WW-1:0]        word_f;
  logic [LANES-1:0]           grant;
  logic                       accept;

  for (genvar g = 0; g < LANES; g++) begin : g_map
    smbc_bank_map #(.AW(AW), .BANK_BITS(BANK_BITS)) i_map (
      .addr (addr_q[g*AW +: AW]),
      .bank (bank_f[g*BANK_BITS +: BANK_BITS]),
      .word (word_f[g*WW +: WW])
    );
  end

  smbc_pass_picker #(.LANES(LANES), .BANK_BITS(BANK_BITS), .WW(WW)) i_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend   (pend_q),
    .bank_f (bank_f),
    .word_f (word_f),
    .grant  (grant)
  );

  assign done        = (pend_q == '0);
  assign req_ready   = done;
  assign accept      = req_valid && req_ready;
  assign grant_valid = !done;
  assign grant_mask  = grant;
  assign degree      = deg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      addr_q <= '0;
      deg_q  <= '0;
    end else if (accept) begin
      pend_q <= req_active;
      addr_q <= req_addr;
      deg_q  <= '0;
    end else if (!done) begin
      pend_q <= pend_q & ~grant;
      deg_q  <= deg_q + 1'b1;
    end
  end

  AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (grant_mask != '0)); // R11
  AST_DEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (degree == $past(degree) + 1'b1)); // R6
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pend_q == $past(req_active))); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && req_valid) |=> ((pend_q & ~$past(pend_q)) == '0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_valid) |=> (done && $stable(degree))); // R8
endmodule

// File: tb/test_smem_bank_arbiter.sv
`timescale 1ns/1ps
module test_smem_bank_arbiter;
  localparam int LANES = 32;
  localparam int AW    = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [LANES-1:0]     req_active = '0;
  logic [LANES*AW-1:0]  req_addr = '0;
  logic                 grant_valid;
  logic [LANES-1:0]     grant_mask;
  logic [5:0]           degree;
  logic                 done;

  always #2.5 clk = ~clk;

  smem_bank_arbiter #(.LANES(LANES), .BANKS(32), .AW(AW)) i_smem_bank_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .grant_valid(grant_valid),
    .grant_mask(grant_mask), .degree(degree), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] a [LANES];
  logic [31:0]   first_grant;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LANES*AW-1:0] packa();
    logic [LANES*AW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*AW +: AW] = a[l];
    return r;
  endfunction

  // expected pass: per bank, the lowest pending lane's word wins
  function automatic logic [31:0] exp_grant(input logic [31:0] pend);
    logic [31:0] g = '0;
    for (int b = 0; b < 32; b++) begin
      int lead = -1;
      for (int l = 0; l < LANES; l++)
        if (lead < 0 && pend[l] && a[l][6:2] == b[4:0]) lead = l;
      if (lead >= 0)
        for (int l = 0; l < LANES; l++)
          if (pend[l] && a[l][15:2] == a[lead][15:2]) g[l] = 1'b1;
    end
    return g;
  endfunction

  task automatic run_req(input logic [31:0] act, input int exp_deg,
                         input bit poke, input string tag);
    logic [31:0] pend_m = act;
    logic [31:0] seen = '0;
    bit seq_ok = 1'b1;
    bit busy_rdy = 1'b0;
    int passes = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
    req_valid  = 1'b1;
    req_active = act;
    req_addr   = packa();
    @(negedge clk);
    if (poke && exp_deg > 0) begin
      req_active = '1;
      req_addr   = ~packa();
    end else req_valid = 1'b0;
    first_grant = grant_mask;
    for (int k = 0; k < 40 && !done; k++) begin
      logic [31:0] eg = exp_grant(pend_m);
      if (!grant_valid || grant_mask != eg) seq_ok = 1'b0;
      if (req_ready) busy_rdy = 1'b1;
      if ((seen & grant_mask) != 0) seq_ok = 1'b0;
      seen   |= grant_mask;
      pend_m &= ~eg;
      passes++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(seq_ok, tag, "grant sequence (R5)", 64'(seen), 64'(act));
    chk(done && !grant_valid, "R11", "done after last pass", 64'({done, grant_valid}), 64'b10);
    chk(passes == exp_deg, "R11", "pass count", 64'(passes), 64'(exp_deg));
    chk(degree == exp_deg, "R6", "degree", 64'(degree), 64'(exp_deg));
    chk(seen == act, "R11", "every lane once", 64'(seen), 64'(act));
    chk(!busy_rdy, "R9", "ready low while busy", 64'(busy_rdy), 64'd0);
  endtask

  typedef struct packed {
    logic [31:0] act;
    logic [15:0] base;
    logic [15:0] stride;
    logic [5:0]  deg;
  } vec_t;

  localparam vec_t VT [12] = '{
    '{32'hFFFF_FFFF, 16'd0, 16'd4,    6'd1},
    '{32'hFFFF_FFFF, 16'd0, 16'd0,    6'd1},
    '{32'hFFFF_FFFF, 16'd0, 16'd1,    6'd1},
    '{32'hFFFF_FFFF, 16'd0, 16'd128,  6'd32},
    '{32'hFFFF_FFFF, 16'd0, 16'd8,    6'd2},
    '{32'hFFFF_FFFF, 16'd2, 16'd132,  6'd1},
    '{32'h0000_FFFF, 16'd0, 16'd64,   6'd8},
    '{32'h0000_0000, 16'd0, 16'd128,  6'd0},
    '{32'h8000_0001, 16'd0, 16'd128,  6'd2},
    '{32'hFFFF_FFFF, 16'd0, 16'd4096, 6'd16},
    '{32'hFFFF_FFFF, 16'd0, 16'd12,   6'd1},
    '{32'hFFFF_FFFF, 16'd0, 16'd2,    6'd1}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 5, 10:  return "R1";
      1, 2, 11:  return "R2";
      3, 4:      return "R3";
      6, 8:      return "R7";
      7:         return "R8";
      default:   return "R4";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(done == 1'b1, "R10", "done", 64'(done), 64'd1);
    chk(req_ready == 1'b1, "R10", "ready", 64'(req_ready), 64'd1);
    chk(grant_valid == 1'b0, "R10", "grant_valid", 64'(grant_valid), 64'd0);
    chk(degree == 0, "R10", "degree", 64'(degree), 64'd0);

    for (int v = 0; v < 12; v++) begin
      for (int l = 0; l < LANES; l++)
        a[l] = VT[v].base + 16'(l) * VT[v].stride;
      run_req(VT[v].act, int'(VT[v].deg), 1'b0, tag_of(v));
    end

    // R8: no active lanes, grant_valid stays low
    chk(grant_valid == 1'b0 && done, "R8", "idle after empty", 64'(grant_valid), 64'd0);

    // R5: lanes 3 and 5 share bank 0 with different words; lane 3 first
    for (int l = 0; l < LANES; l++) a[l] = 16'(l) * 16'd4;
    a[3] = 16'd128;
    a[5] = 16'd0;
    run_req(32'h0000_0028, 2, 1'b0, "R5");
    chk(first_grant == 32'h0000_0008, "R5", "lowest lane first", 64'(first_grant), 64'h8);

    // R3: 0 vs 132 no conflict, 0 vs 128 conflict
    a[0] = 16'd0; a[1] = 16'd132;
    run_req(32'h0000_0003, 1, 1'b0, "R3");
    a[1] = 16'd128;
    run_req(32'h0000_0003, 2, 1'b0, "R3");

    // R9: request held valid while busy must be ignored
    for (int l = 0; l < LANES; l++) a[l] = 16'(l) * 16'd256;
    run_req(32'h0000_00FF, 8, 1'b1, "R9");
    @(negedge clk);
    chk(done && degree == 8, "R9", "busy request ignored", 64'(degree), 64'd8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule